// File: doc/BRIEF.md
# Tick Counter with Compare Match

This block is a free-running processor tick counter that advances by one on every clock. Software can load the count and read it back, and it can write a compare limit. When the count reaches the armed limit, the block emits a one-cycle match pulse. That pulse sets the timer-match bit in the software-interrupt register. The same design is instanced twice: once as the tick timer and once as the system tick timer.

The most significant bit of each written word is an interrupt-disable flag. A count write and a limit write both update it. A count read returns the 63-bit counter value with the flag in the top bit. A limit of zero never fires. A limit that is already at or below the current count fires on the next clock. After a match the compare stays disarmed until software writes a new limit.

Top module: `tick_cmp_timer`

## Requirements
- R1: After reset the disable flag is set, the count is zero (a read returns 0x8000_0000_0000_0000), no compare is armed and `match_o` is low.
- R2: Without a count write, the 63-bit counter value increases by exactly one per clock.
- R3: A count write loads bits [62:0] as the counter value, which is readable in the cycle after the write edge, and sets the disable flag from bit 63.
- R4: Bit 63 of the count read equals the disable flag; bits [62:0] are the counter value.
- R5: A limit write sets the disable flag from its bit 63. When a count write and a limit write share a cycle, the limit's bit 63 decides the flag.
- R6: With a nonzero limit L armed and the flag clear, `match_o` is high for exactly one cycle: the cycle after the counter equals L, when the count reads L+1.
- R7: Writing a limit of zero disarms the compare, and no match follows.
- R8: While the disable flag is set, no match is produced.
- R9: A limit written at or below the counter value present at the write edge is overdue; if the flag is clear, `match_o` rises one cycle after the write edge.
- R10: After a match the compare stays disarmed, so the counter passing L again gives no match until the next limit write.
- R11: The counter wraps from 2^63-1 to 0 and leaves the disable flag unchanged.
- R12: A count write discards a pending overdue condition; the armed limit then fires only on equality.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the counter advances on each rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnt_we_i | input | 1 | Count write strobe |
| cnt_wdata_i | input | 64 | Count write word: bit 63 = disable, [62:0] = value |
| lim_we_i | input | 1 | Limit write strobe |
| lim_wdata_i | input | 64 | Limit write word: bit 63 = disable, [62:0] = compare |
| cnt_rdata_o | output | 64 | Count read: bit 63 = disable flag, [62:0] = counter |
| match_o | output | 1 | One-cycle timer-match pulse |

## Verification
A corrupted counter or disable flag shows up on the count read port in the very next cycle, because the read port shows both directly. Compare-side faults cannot be seen on the read port; they show up only on `match_o`. A stale overdue flag fires a pulse one cycle after a count write instead of at equality. An armed bit that is not cleared fires again when the counter passes the limit a second time. A missing or shifted pulse is caught because every expected match is queued with its exact cycle number and compared against the cycle of the observed pulse.

// File: rtl/tick_pkg.sv
package tick_pkg;

  typedef enum logic [1:0] {
    DIS_KEEP = 2'd0,
    DIS_CNT  = 2'd1,
    DIS_LIM  = 2'd2
  } dis_src_e;

  // limit write is the later writer of the shared flag
  function automatic dis_src_e dis_select(input logic cnt_we, input logic lim_we);
    if (lim_we)      return DIS_LIM;
    else if (cnt_we) return DIS_CNT;
    else             return DIS_KEEP;
  endfunction

endpackage

// File: rtl/tick_counter.sv
module tick_counter
  import tick_pkg::*;
#(
  parameter int unsigned VAL_W = 63
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_we_i,
  input  logic [VAL_W-1:0] cnt_val_i,
  input  logic             cnt_dis_i,
  input  logic             lim_we_i,
  input  logic             lim_dis_i,
  output logic [VAL_W-1:0] cnt_o,
  output logic             dis_o
);

  logic [VAL_W-1:0] cnt_q;
  logic             dis_q;
  dis_src_e         dis_src;

  assign dis_src = dis_select(cnt_we_i, lim_we_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_we_i) begin
      cnt_q <= cnt_val_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;  // natural wrap at 2^VAL_W
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dis_q <= 1'b1;
    end else begin
      unique case (dis_src)
        DIS_LIM: dis_q <= lim_dis_i;
        DIS_CNT: dis_q <= cnt_dis_i;
        default: dis_q <= dis_q;
      endcase
    end
  end

  assign cnt_o = cnt_q;
  assign dis_o = dis_q;

  a_r2_incr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_we_i |=> cnt_o == VAL_W'($past(cnt_o) + 1'b1));

  a_r3_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> cnt_o == $past(cnt_val_i));

  a_r5_lim_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lim_we_i |=> dis_o == $past(lim_dis_i));

endmodule

// File: rtl/tick_compare.sv
module tick_compare #(
  parameter int unsigned VAL_W = 63
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lim_we_i,
  input  logic [VAL_W-1:0] lim_val_i,
  input  logic             cnt_we_i,
  input  logic [VAL_W-1:0] cnt_i,
  input  logic             dis_i,
  output logic             match_o
);

  logic [VAL_W-1:0] lim_q;
  logic             armed_q;
  logic             late_q;
  logic             match_q;
  logic             fire;

  assign fire = armed_q && !dis_i && (late_q || (cnt_i == lim_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_q   <= '0;
      armed_q <= 1'b0;
      late_q  <= 1'b0;
    end else if (lim_we_i) begin
      lim_q   <= lim_val_i;
      armed_q <= |lim_val_i;
      // overdue only against the count present now; a count write voids it
      late_q  <= (lim_val_i <= cnt_i) && !cnt_we_i;
    end else begin
      if (fire) begin
        armed_q <= 1'b0;
        late_q  <= 1'b0;
      end else if (cnt_we_i) begin
        late_q  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) match_q <= 1'b0;
    else         match_q <= fire;
  end

  assign match_o = match_q;

  a_r8_no_match_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> !$past(dis_i));

  a_r10_disarm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && !$past(lim_we_i)) |-> !armed_q);

  a_r7_zero_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lim_we_i && lim_val_i == '0) |=> !armed_q);

endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             lim_we_i,
  input  logic [CNT_W-1:0] lim_wdata_i,
  output logic [CNT_W-1:0] cnt_rdata_o,
  output logic             match_o
);

  localparam int unsigned VAL_W = CNT_W - 1;

  logic [VAL_W-1:0] cnt;
  logic             dis;

  tick_counter #(.VAL_W(VAL_W)) u_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_we_i  (cnt_we_i),
    .cnt_val_i (cnt_wdata_i[VAL_W-1:0]),
    .cnt_dis_i (cnt_wdata_i[VAL_W]),
    .lim_we_i  (lim_we_i),
    .lim_dis_i (lim_wdata_i[VAL_W]),
    .cnt_o     (cnt),
    .dis_o     (dis)
  );

  tick_compare #(.VAL_W(VAL_W)) u_compare (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lim_we_i  (lim_we_i),
    .lim_val_i (lim_wdata_i[VAL_W-1:0]),
    .cnt_we_i  (cnt_we_i),
    .cnt_i     (cnt),
    .dis_i     (dis),
    .match_o   (match_o)
  );

  assign cnt_rdata_o = {dis, cnt};

endmodule

// File: tb/tick_cmp_timer_tb_top.sv
module tick_cmp_timer_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cnt_we_i = 1'b0;
  logic [63:0] cnt_wdata_i = '0;
  logic        lim_we_i = 1'b0;
  logic [63:0] lim_wdata_i = '0;
  logic [63:0] cnt_rdata_o;
  logic        match_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int n_match = 0;
  bit done = 1'b0;
  string quiet_req = "R10";
  int exp_q[$];

  always #4 clk_i = ~clk_i;

  tick_cmp_timer dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cnt_we_i(cnt_we_i), .cnt_wdata_i(cnt_wdata_i),
    .lim_we_i(lim_we_i), .lim_wdata_i(lim_wdata_i),
    .cnt_rdata_o(cnt_rdata_o), .match_o(match_o)
  );

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // monitor: pop the expected cycle for every observed pulse
  always @(negedge clk_i) begin
    if (rst_ni && match_o) begin
      n_match++;
      if (exp_q.size() == 0) chk(1'b0, quiet_req, 64'(cyc), 64'hffff_ffff);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(cyc == e, "R6", 64'(cyc), 64'(e));
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr_cnt(input logic [63:0] v);
    @(negedge clk_i); cnt_we_i = 1'b1; cnt_wdata_i = v;
    @(negedge clk_i); cnt_we_i = 1'b0;
  endtask

  // driver: predicts the match cycle and pushes it to the scoreboard
  task automatic wr_lim(input logic [63:0] v);
    longint unsigned l, c;
    @(negedge clk_i); lim_we_i = 1'b1; lim_wdata_i = v;
    @(negedge clk_i); lim_we_i = 1'b0;
    l = longint'(v[62:0]);
    c = longint'(cnt_rdata_o[62:0]);
    if (!cnt_rdata_o[63] && l != 0)
      exp_q.push_back(cyc + ((l > c) ? int'(l - c) : 0) + 1);
  endtask

  initial begin
    repeat (1000) @(posedge clk_i);
    forever begin
      @(posedge clk_i);
      if (done) break;
      if (cyc > 100000) begin
        chk(1'b0, "watchdog", 64'(cyc), 64'd100000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [63:0] a, b;
    int k, m0;
    idle(3);
    chk(cnt_rdata_o == 64'h8000_0000_0000_0000, "R1", cnt_rdata_o, 64'h8000_0000_0000_0000);
    chk(match_o == 1'b0, "R1", 64'(match_o), 64'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    idle(2);

    // R2 free running
    a = cnt_rdata_o; idle(1); b = cnt_rdata_o;
    chk(b == a + 1, "R2", b, a + 1);
    chk(b[63] == 1'b1, "R4", 64'(b[63]), 64'd1);

    // R3 load, enable, keep counting
    wr_cnt(64'd100);
    chk(cnt_rdata_o == 64'd100, "R3", cnt_rdata_o, 64'd100);
    idle(3);
    chk(cnt_rdata_o == 64'd103, "R2", cnt_rdata_o, 64'd103);

    // R4 flag read back in bit 63
    wr_cnt({1'b1, 63'd5});
    chk(cnt_rdata_o == {1'b1, 63'd5}, "R4", cnt_rdata_o, {1'b1, 63'd5});

    // R6 equality match, two patterns
    quiet_req = "R6";
    wr_cnt(64'd0);
    wr_lim(64'd20);
    idle(40);
    wr_cnt(64'd1000);
    wr_lim(64'd1040);
    idle(60);
    chk(exp_q.size() == 0, "R6", 64'(exp_q.size()), 64'd0);
    chk(n_match == 2, "R6", 64'(n_match), 64'd2);

    // R7 zero limit never fires
    quiet_req = "R7";
    m0 = n_match;
    wr_cnt(64'd0);
    wr_lim(64'd0);
    idle(50);
    chk(n_match == m0, "R7", 64'(n_match), 64'(m0));

    // R8 disabled through the limit word; R5 flag from limit
    quiet_req = "R8";
    wr_cnt(64'd0);
    wr_lim({1'b1, 63'd10});
    chk(cnt_rdata_o[63] == 1'b1, "R5", 64'(cnt_rdata_o[63]), 64'd1);
    idle(30);
    chk(n_match == m0, "R8", 64'(n_match), 64'(m0));

    // R12 overdue limit written while disabled, then count write enables
    quiet_req = "R12";
    wr_lim({1'b1, 63'd5});
    wr_cnt(64'd0);
    k = cyc;
    exp_q.push_back(k + 6);
    idle(15);
    chk(n_match == m0 + 1, "R12", 64'(n_match), 64'(m0 + 1));

    // R9 overdue limit fires on the next cycle
    quiet_req = "R9";
    wr_lim(64'd3);
    idle(3);
    chk(n_match == m0 + 2, "R9", 64'(n_match), 64'(m0 + 2));

    // R10 one shot: counter passes 3 again, no pulse
    quiet_req = "R10";
    wr_cnt(64'd0);
    idle(20);
    chk(n_match == m0 + 2, "R10", 64'(n_match), 64'(m0 + 2));

    // R5 simultaneous writes: limit bit 63 decides
    quiet_req = "R5";
    @(negedge clk_i);
    cnt_we_i = 1'b1; cnt_wdata_i = 64'd50;
    lim_we_i = 1'b1; lim_wdata_i = {1'b1, 63'd60};
    @(negedge clk_i); cnt_we_i = 1'b0; lim_we_i = 1'b0;
    chk(cnt_rdata_o == {1'b1, 63'd50}, "R5", cnt_rdata_o, {1'b1, 63'd50});
    @(negedge clk_i);
    cnt_we_i = 1'b1; cnt_wdata_i = {1'b1, 63'd70};
    lim_we_i = 1'b1; lim_wdata_i = 64'd0;
    @(negedge clk_i); cnt_we_i = 1'b0; lim_we_i = 1'b0;
    chk(cnt_rdata_o == 64'd70, "R5", cnt_rdata_o, 64'd70);
    idle(20);

    // R11 wrap, flag untouched
    quiet_req = "R11";
    wr_cnt(64'h7fff_ffff_ffff_fffe);
    idle(2);
    chk(cnt_rdata_o == 64'd0, "R11", cnt_rdata_o, 64'd0);
    wr_cnt(64'hffff_ffff_ffff_ffff);
    idle(1);
    chk(cnt_rdata_o == 64'h8000_0000_0000_0000, "R11", cnt_rdata_o, 64'h8000_0000_0000_0000);

    idle(5);
    chk(exp_q.size() == 0, "R6", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule